// File: doc/BRIEF.md
# Event-Gated Performance Counter Bank

This block is a bank of four performance counters for a processor's debug and profiling logic. Each channel picks one increment source through an item selector. A gate decides in which cycles the channel counts. In window mode, configured start and end event pulses open and close the gate. In free mode, the gate follows the run indicator until a halting event arrives. When only one of the two edges is configured, the gate stays shut. Some items carry their own weights: a branch adds two, and any number of simultaneous pending waits add one.

The four channels form two pairs: (0,1) and (2,3). When a pair is chained, the lower channel holds the low word and the upper channel holds the high word of a double-width counter. The high word advances only on the low word's carry. An initialise command clears every count, every overflow flag and every gate. Counters wrap on overflow and keep a sticky flag. The event sources themselves are produced elsewhere.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset every count reads 0 and every overflow flag reads 0. Each counter is CNT_W bits wide (32 by default).
- R2: Item codes 0 and 3 to 6 weigh 1. Code 0 adds 1 in every counting cycle. Code 3+k adds 1 in each counting cycle with `ev_i[k]` high. Code 7 never adds. Each channel counts independently of the others.
- R3: Item code 1 adds 2 in each counting cycle in which `branch_i` is high.
- R4: Item code 2 adds 1 in each counting cycle in which at least one bit of `wait_req_i` is high, however many bits are high.
- R5: With both `use_start_i` and `use_end_i` set, counting begins in the cycle of a start pulse. It includes the cycle of the end pulse and stops after it. Coincident start and end pulses count exactly that one cycle. An end pulse while closed has no effect.
- R6: With neither set, the channel counts every cycle with `run_i` high. After a `halt_i` pulse it stops counting, though that cycle itself counts if `run_i` is high. It stays stopped until initialise.
- R7: With exactly one of `use_start_i`/`use_end_i` set, the channel never counts.
- R8: With `chain_i[p]` set, channel 2p is the low word and channel 2p+1 the high word of one counter. The high word advances only by the low word's carry, and its own gate and item are ignored. The low word's overflow flag is not set.
- R9: A counter wraps modulo 2^CNT_W and sets its overflow flag, which stays set until initialise. A chained pair sets the high channel's flag on a wrap of the whole double-width value.
- R10: `init_i` clears all counts, flags and gate state in the next cycle. It takes priority over any increment or start pulse in the same cycle. Afterwards free-mode channels count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Clear counts, flags and gates |
| run_i | input | 1 | Program running indicator |
| halt_i | input | 1 | Event condition met, stops free-mode channels |
| start_i | input | NUM_CH | Per-channel start event pulse |
| end_i | input | NUM_CH | Per-channel end event pulse |
| use_start_i | input | NUM_CH | Start condition configured |
| use_end_i | input | NUM_CH | End condition configured |
| chain_i | input | NUM_CH/2 | Join pair p into one double-width counter |
| item_sel_i | input | NUM_CH x 3 | Item code per channel |
| branch_i | input | 1 | Branch taken this cycle |
| wait_req_i | input | WAIT_W | Outstanding requests waiting for acceptance |
| ev_i | input | NUM_EV | Generic single-weight events |
| count_o | output | NUM_CH x CNT_W | Counter values |
| ovf_o | output | NUM_CH | Sticky overflow flags |

## Verification
Two pairs of functions can land in the same cycle. One is a start and an end pulse on the same channel. The other is initialise and an increment or start pulse. Both are driven on purpose. Coincident start and end must leave exactly one counted cycle, with no further growth over later cycles with stimulus held. Initialise must win over the increment and over the start pulse, leaving zero both in the next cycle and a few cycles later. The bench uses an 8-bit counter width so that wrap, sticky flags and the double-width carry across a chained pair come within reach.

// File: rtl/perf_pkg.sv
`timescale 1ns/1ps
package perf_pkg;
  localparam int SEL_W = 3;
  localparam int INC_W = 2;

  localparam logic [SEL_W-1:0] ITEM_CYCLES = 3'd0;
  localparam logic [SEL_W-1:0] ITEM_BRANCH = 3'd1;
  localparam logic [SEL_W-1:0] ITEM_WAIT   = 3'd2;
  localparam int               ITEM_EV_BASE = 3;

  typedef enum logic [1:0] {
    GATE_OFF    = 2'd0,
    GATE_FREE   = 2'd1,
    GATE_WINDOW = 2'd2
  } gate_mode_e;
endpackage

// File: rtl/perf_gate.sv
`timescale 1ns/1ps
module perf_gate
  import perf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic run_i,
  input  logic halt_i,
  input  logic start_i,
  input  logic end_i,
  input  logic use_start_i,
  input  logic use_end_i,
  output logic active_o
);
  gate_mode_e mode;
  logic open_q, done_q;

  always_comb begin
    if (use_start_i && use_end_i)        mode = GATE_WINDOW;
    else if (!use_start_i && !use_end_i) mode = GATE_FREE;
    else                                 mode = GATE_OFF;
  end

  always_comb begin
    case (mode)
      GATE_WINDOW: active_o = open_q | start_i;
      GATE_FREE:   active_o = run_i & ~done_q;
      default:     active_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      done_q <= 1'b0;
    end else if (init_i) begin
      open_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      // end cycle is still counted; window closes after it
      if (mode == GATE_WINDOW) open_q <= (open_q | start_i) & ~end_i;
      if (mode == GATE_FREE && halt_i) done_q <= 1'b1;
    end
  end

  assert_window_closes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == GATE_WINDOW && end_i && !init_i) |=>
      (mode != GATE_WINDOW || start_i || !active_o));

  assert_free_halts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == GATE_FREE && halt_i && !init_i) |=> (mode != GATE_FREE || !active_o));
endmodule

// File: rtl/perf_inc_sel.sv
`timescale 1ns/1ps
module perf_inc_sel
  import perf_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int NUM_EV = 4
) (
  input  logic [SEL_W-1:0]  item_i,
  input  logic              branch_i,
  input  logic [WAIT_W-1:0] wait_req_i,
  input  logic [NUM_EV-1:0] ev_i,
  output logic [INC_W-1:0]  inc_o
);
  always_comb begin
    inc_o = '0;
    if (item_i == ITEM_CYCLES) begin
      inc_o = INC_W'(1);
    end else if (item_i == ITEM_BRANCH) begin
      inc_o = branch_i ? INC_W'(2) : '0;
    end else if (item_i == ITEM_WAIT) begin
      // simultaneous waits weigh one
      inc_o = INC_W'(|wait_req_i);
    end else begin
      for (int k = 0; k < NUM_EV; k++) begin
        if (item_i == SEL_W'(ITEM_EV_BASE + k) && ev_i[k]) inc_o = INC_W'(1);
      end
    end
  end
endmodule

// File: rtl/perf_pair.sv
`timescale 1ns/1ps
module perf_pair
  import perf_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             chain_i,
  input  logic             act_lo_i,
  input  logic             act_hi_i,
  input  logic [INC_W-1:0] inc_lo_i,
  input  logic [INC_W-1:0] inc_hi_i,
  output logic [CNT_W-1:0] cnt_lo_o,
  output logic [CNT_W-1:0] cnt_hi_o,
  output logic             ovf_lo_o,
  output logic             ovf_hi_o
);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] NEAR_TOP = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [SUM_W-1:0] sum_lo, sum_hi;
  logic [SUM_W-1:0] add_lo, add_hi;
  logic carry_lo, carry_hi;

  always_comb begin
    add_lo   = SUM_W'(act_lo_i ? inc_lo_i : '0);
    sum_lo   = {1'b0, cnt_lo_o} + add_lo;
    carry_lo = sum_lo[CNT_W];
    add_hi   = chain_i ? SUM_W'(carry_lo) : SUM_W'(act_hi_i ? inc_hi_i : '0);
    sum_hi   = {1'b0, cnt_hi_o} + add_hi;
    carry_hi = sum_hi[CNT_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_lo_o <= '0;
      cnt_hi_o <= '0;
      ovf_lo_o <= 1'b0;
      ovf_hi_o <= 1'b0;
    end else if (init_i) begin
      cnt_lo_o <= '0;
      cnt_hi_o <= '0;
      ovf_lo_o <= 1'b0;
      ovf_hi_o <= 1'b0;
    end else begin
      cnt_lo_o <= sum_lo[CNT_W-1:0];
      cnt_hi_o <= sum_hi[CNT_W-1:0];
      if (carry_lo && !chain_i) ovf_lo_o <= 1'b1;
      if (carry_hi)             ovf_hi_o <= 1'b1;
    end
  end

  assert_lo_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !act_lo_i) |=> $stable(cnt_lo_o));

  assert_step_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_i |=> (CNT_W'(cnt_lo_o - $past(cnt_lo_o)) <= CNT_W'(2)));

  assert_init_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (cnt_lo_o == '0 && cnt_hi_o == '0 && !ovf_lo_o && !ovf_hi_o));

  assert_sticky_ovf_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_lo_o && !init_i) |=> ovf_lo_o);

  assert_chain_hi_carry_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain_i && !init_i && cnt_lo_o < NEAR_TOP) |=> $stable(cnt_hi_o));
endmodule

// File: rtl/perf_counter_bank.sv
`timescale 1ns/1ps
module perf_counter_bank
  import perf_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int WAIT_W = 4,
  parameter int NUM_EV = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          init_i,
  input  logic                          run_i,
  input  logic                          halt_i,
  input  logic [NUM_CH-1:0]             start_i,
  input  logic [NUM_CH-1:0]             end_i,
  input  logic [NUM_CH-1:0]             use_start_i,
  input  logic [NUM_CH-1:0]             use_end_i,
  input  logic [NUM_CH/2-1:0]           chain_i,
  input  logic [NUM_CH-1:0][SEL_W-1:0]  item_sel_i,
  input  logic                          branch_i,
  input  logic [WAIT_W-1:0]             wait_req_i,
  input  logic [NUM_EV-1:0]             ev_i,
  output logic [NUM_CH-1:0][CNT_W-1:0]  count_o,
  output logic [NUM_CH-1:0]             ovf_o
);
  localparam int NUM_PAIR = NUM_CH / 2;

  logic [NUM_CH-1:0]            active;
  logic [NUM_CH-1:0][INC_W-1:0] inc;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    perf_gate u_gate (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .init_i      (init_i),
      .run_i       (run_i),
      .halt_i      (halt_i),
      .start_i     (start_i[c]),
      .end_i       (end_i[c]),
      .use_start_i (use_start_i[c]),
      .use_end_i   (use_end_i[c]),
      .active_o    (active[c])
    );

    perf_inc_sel #(.WAIT_W(WAIT_W), .NUM_EV(NUM_EV)) u_sel (
      .item_i     (item_sel_i[c]),
      .branch_i   (branch_i),
      .wait_req_i (wait_req_i),
      .ev_i       (ev_i),
      .inc_o      (inc[c])
    );
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    perf_pair #(.CNT_W(CNT_W)) u_pair (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .init_i   (init_i),
      .chain_i  (chain_i[p]),
      .act_lo_i (active[2*p]),
      .act_hi_i (active[2*p+1]),
      .inc_lo_i (inc[2*p]),
      .inc_hi_i (inc[2*p+1]),
      .cnt_lo_o (count_o[2*p]),
      .cnt_hi_o (count_o[2*p+1]),
      .ovf_lo_o (ovf_o[2*p]),
      .ovf_hi_o (ovf_o[2*p+1])
    );
  end
endmodule

// File: tb/sim_perf_counter_bank.sv
`timescale 1ns/1ps
module sim_perf_counter_bank;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic init_i = 1'b0, run_i = 1'b0, halt_i = 1'b0;
  logic [3:0] start_i = '0, end_i = '0, use_start_i = '0, use_end_i = '0;
  logic [1:0] chain_i = '0;
  logic [3:0][2:0] item_sel_i = '0;
  logic branch_i = 1'b0;
  logic [3:0] wait_req_i = '0;
  logic [3:0] ev_i = '0;
  logic [3:0][CW-1:0] count_o;
  logic [3:0] ovf_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  perf_counter_bank #(.NUM_CH(4), .CNT_W(CW), .WAIT_W(4), .NUM_EV(4)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .init_i(init_i), .run_i(run_i), .halt_i(halt_i),
    .start_i(start_i), .end_i(end_i), .use_start_i(use_start_i), .use_end_i(use_end_i),
    .chain_i(chain_i), .item_sel_i(item_sel_i), .branch_i(branch_i),
    .wait_req_i(wait_req_i), .ev_i(ev_i), .count_o(count_o), .ovf_o(ovf_o)
  );

  typedef struct packed {
    logic [2:0] item;
    logic       br;
    logic [3:0] wt;
    logic [3:0] ev;
    logic [7:0] n;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{3'd0, 1'b0, 4'h0, 4'h0, 8'd5, 8'd5},
    '{3'd1, 1'b1, 4'h0, 4'h0, 8'd4, 8'd8},
    '{3'd1, 1'b0, 4'h0, 4'h0, 8'd4, 8'd0},
    '{3'd2, 1'b0, 4'hB, 4'h0, 8'd3, 8'd3},
    '{3'd2, 1'b0, 4'h1, 4'h0, 8'd6, 8'd6},
    '{3'd3, 1'b0, 4'h0, 4'h1, 8'd7, 8'd7},
    '{3'd6, 1'b0, 4'h0, 4'h8, 8'd2, 8'd2},
    '{3'd4, 1'b0, 4'h0, 4'h1, 8'd3, 8'd0},
    '{3'd7, 1'b1, 4'hF, 4'hF, 8'd3, 8'd0}
  };

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_init();
    init_i = 1'b1;
    cyc();
    init_i = 1'b0;
  endtask

  // open window on ch0 for n cycles, end pulse in the last one
  task automatic window0(int n);
    for (int i = 0; i < n; i++) begin
      start_i[0] = (i == 0);
      end_i[0]   = (i == n - 1);
      cyc();
    end
    start_i[0] = 1'b0;
    end_i[0]   = 1'b0;
  endtask

  initial begin
    cyc(2);
    rst_ni = 1'b1;
    cyc();
    for (int c = 0; c < 4; c++) begin
      chk("R1 reset count", count_o[c], 0);
      chk("R1 reset ovf", ovf_o[c], 0);
    end

    // vector table on ch0 in window mode
    use_start_i = 4'b0001;
    use_end_i   = 4'b0001;
    for (int v = 0; v < 9; v++) begin
      string req;
      req = (VECS[v].item == 3'd1) ? "R3 branch" :
            (VECS[v].item == 3'd2) ? "R4 wait" : "R2 item";
      do_init();
      item_sel_i[0] = VECS[v].item;
      branch_i = VECS[v].br;
      wait_req_i = VECS[v].wt;
      ev_i = VECS[v].ev;
      window0(int'(VECS[v].n));
      branch_i = 1'b0; wait_req_i = '0; ev_i = '0;
      chk(req, count_o[0], VECS[v].exp);
    end

    // R5 coincident start/end, stray end, later window
    do_init();
    item_sel_i[0] = 3'd0;
    start_i[0] = 1'b1; end_i[0] = 1'b1;
    cyc();
    start_i[0] = 1'b0; end_i[0] = 1'b0;
    chk("R5 same-cycle start/end", count_o[0], 1);
    cyc(3);
    chk("R5 stopped after end", count_o[0], 1);
    end_i[0] = 1'b1; cyc(); end_i[0] = 1'b0; cyc();
    chk("R5 end while closed", count_o[0], 1);
    window0(3);
    chk("R5 reopened window", count_o[0], 4);

    // R7 only one edge configured
    do_init();
    item_sel_i[1] = 3'd0;
    use_start_i[1] = 1'b1; use_end_i[1] = 1'b0;
    run_i = 1'b1;
    start_i[1] = 1'b1; end_i[1] = 1'b1; cyc();
    start_i[1] = 1'b0; end_i[1] = 1'b0; cyc(3);
    chk("R7 start only", count_o[1], 0);
    use_start_i[1] = 1'b0; use_end_i[1] = 1'b1;
    start_i[1] = 1'b1; cyc(); start_i[1] = 1'b0; cyc(3);
    chk("R7 end only", count_o[1], 0);
    use_end_i[1] = 1'b0;
    run_i = 1'b0;

    // R6 free mode on ch2
    do_init();
    item_sel_i[2] = 3'd0;
    run_i = 1'b1;
    cyc(3);
    halt_i = 1'b1; cyc(); halt_i = 1'b0;
    chk("R6 counted through halt", count_o[2], 4);
    cyc(3);
    chk("R6 stopped after halt", count_o[2], 4);
    chk("R5 closed window ignores run", count_o[0], 0);
    run_i = 1'b0;
    do_init();
    chk("R10 init clears", count_o[2], 0);
    run_i = 1'b1; cyc(2); run_i = 1'b0; cyc(2);
    chk("R6 re-enabled, run low ignored", count_o[2], 2);

    // R2 independent channels
    do_init();
    item_sel_i[0] = 3'd1;
    branch_i = 1'b1;
    run_i = 1'b1;
    window0(5);
    run_i = 1'b0; branch_i = 1'b0;
    cyc();
    chk("R2 ch0 branches", count_o[0], 10);
    chk("R2 ch2 cycles", count_o[2], 5);

    // R9 wrap and sticky flag
    do_init();
    item_sel_i[0] = 3'd1;
    branch_i = 1'b1;
    window0(128);
    branch_i = 1'b0;
    chk("R9 wrapped value", count_o[0], 0);
    chk("R9 overflow set", ovf_o[0], 1);
    item_sel_i[0] = 3'd0;
    window0(1);
    chk("R9 count after wrap", count_o[0], 1);
    chk("R9 flag sticky", ovf_o[0], 1);
    do_init();
    chk("R10 flag cleared", ovf_o[0], 0);

    // R10 init beats increment and start pulse
    init_i = 1'b1; start_i[0] = 1'b1; cyc();
    init_i = 1'b0; start_i[0] = 1'b0;
    chk("R10 init priority", count_o[0], 0);
    cyc(2);
    chk("R10 gate cleared", count_o[0], 0);

    // R8 chaining pair 0; ch1 free with run high would count alone
    do_init();
    chain_i[0] = 1'b1;
    item_sel_i[0] = 3'd0;
    item_sel_i[1] = 3'd0;
    run_i = 1'b1;
    window0(300);
    run_i = 1'b0;
    chk("R8 low word", count_o[0], 44);
    chk("R8 high word", count_o[1], 1);
    chk("R8 low flag clear", ovf_o[0], 0);
    do_init();
    item_sel_i[0] = 3'd1;
    branch_i = 1'b1;
    window0(32768);
    branch_i = 1'b0;
    chk("R9 chained wrap low", count_o[0], 0);
    chk("R9 chained wrap high", count_o[1], 0);
    chk("R9 chained high flag", ovf_o[1], 1);
    chk("R8 chained low flag", ovf_o[0], 0);
    chain_i = '0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule